// File: doc/BRIEF.md
# Clock Root Settings Register Bank

This block is the software-facing register bank of a single clock root generator. It holds a small set of staged settings for the root: which of up to eight sources to take, a half-integer pre-divider value, a counter mode, and the three values that drive a fractional M/N counter. Software writes these through a plain synchronous register port. Each write lands in a staging (shadow) copy and raises a per-register pending-change flag. Nothing downstream changes until software asks for an update.

An update request is raised by writing a one to the lowest bit of the command word. The request stays visible in that bit while it crosses into the clock path, which is modelled as a fixed number of cycles. At the end of that window every flagged staging value is copied to the active outputs in one edge, all flags drop, the request bit clears itself and a one-cycle apply pulse goes to the clock path. The command word also carries a root-enable request that acts at once and a read-only status bit that shows whether the root clock is stopped.

Top module: `clkroot_cfg_bank`

## Requirements
- R1: After reset every staging value, every active output, the change flags, the update request and the root-enable request are zero.
- R2: The map is command at 0x00, configuration at 0x04, M at 0x08, N at 0x0C and D at 0x10; any other address reads zero and a write to it changes no state.
- R3: Configuration holds the pre-divider in bits DIV_W-1:0, the source select in bits 10:8 and the counter mode in bits 13:12; all other bits read zero and their written values are dropped.
- R4: M, N and D keep only their low MND_W bits; higher bits read zero.
- R5: Command bit 31 reads 1 when the root clock is reported stopped (root_on_i low) and 0 while it runs; writes to it have no effect.
- R6: Command bit 1 is the root-enable request; it reads back as written and drives root_en_o from the edge of the write, without waiting for an update.
- R7: A write to configuration, N, M or D sets command bit 4, 5, 6 or 7 respectively; writes to those bits from the port are dropped.
- R8: Writing 1 to command bit 0 when no update is pending sets it; it then reads 1 for exactly SYNC_STAGES cycles and clears itself; writes to bit 0 while it is set (0 or 1) neither cancel nor restart the update.
- R9: The active outputs change only on the commit edge, where every flagged staging value is copied, all change flags clear and apply_o is high for that cycle.
- R10: A staging write on the commit edge itself leaves its new value staged: the active output takes the value staged before that write and the write's change flag remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for the current address, combinational |
| root_on_i | input | 1 | High while the root clock is running |
| root_en_o | output | 1 | Root-enable request to the clock path |
| apply_o | output | 1 | One-cycle pulse on the commit edge |
| act_div_o | output | DIV_W | Active pre-divider value |
| act_src_o | output | 3 | Active source select |
| act_mode_o | output | 2 | Active counter mode (2 = dual-edge M/N) |
| act_m_o | output | MND_W | Active M value |
| act_n_o | output | MND_W | Active N value as written |
| act_d_o | output | MND_W | Active D value as written |

## Verification
The hardest situation to reach is a staging write that arrives on the very edge the pending update commits, because it needs the write placed exactly SYNC_STAGES cycles after the request. The bench counts cycles from the request edge and issues an M write in the commit cycle, then checks that the active M carries the earlier value, that the M change flag is still set, and that a second update then carries the new value. Writes to the request bit inside the window are also placed on chosen cycles to show that they neither cancel nor restart the countdown.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_CMD = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG = 5'h04;

  // M, N and D staging slots: index 0 = M, 1 = N, 2 = D
  localparam int NUM_MND = 3;
  localparam logic [ADDR_W-1:0] MND_OFS [NUM_MND] = '{5'h08, 5'h0C, 5'h10};
  // change flag index (command bit = FLAG_LSB + index)
  localparam int MND_FLAG [NUM_MND] = '{2, 1, 3};
  localparam int FLAG_CFG = 0;
  localparam int NUM_FLAG = 4;

  localparam int CMD_UPD_BIT  = 0;
  localparam int CMD_EN_BIT   = 1;
  localparam int CMD_FLAG_LSB = 4;
  localparam int CMD_OFF_BIT  = 31;

  localparam int CFG_SRC_LSB  = 8;
  localparam int SRC_W        = 3;
  localparam int CFG_MODE_LSB = 12;
  localparam int MODE_W       = 2;
endpackage

// File: rtl/clkroot_stage.sv
module clkroot_stage
  import clkroot_pkg::*;
#(
  parameter int DIV_W = 5,
  parameter int MND_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [BUS_W-1:0]                wdata,
  input  logic                            flag_clr,
  output logic [DIV_W-1:0]                st_div,
  output logic [SRC_W-1:0]                st_src,
  output logic [MODE_W-1:0]               st_mode,
  output logic [NUM_MND-1:0][MND_W-1:0]   st_mnd,
  output logic [NUM_FLAG-1:0]             flags,
  output logic                            en_req
);
  logic [DIV_W-1:0]              div_q, div_d;
  logic [SRC_W-1:0]              src_q, src_d;
  logic [MODE_W-1:0]             mode_q, mode_d;
  logic [NUM_MND-1:0][MND_W-1:0] mnd_q, mnd_d;
  logic [NUM_FLAG-1:0]           flag_q, flag_d;
  logic                          en_q, en_d;
  logic                          unused_wdata;

  assign unused_wdata = ^wdata;

  always_comb begin
    div_d  = div_q;
    src_d  = src_q;
    mode_d = mode_q;
    mnd_d  = mnd_q;
    en_d   = en_q;
    flag_d = flag_clr ? '0 : flag_q;
    if (wr_en) begin
      if (addr == OFS_CFG) begin
        div_d            = wdata[DIV_W-1:0];
        src_d            = wdata[CFG_SRC_LSB +: SRC_W];
        mode_d           = wdata[CFG_MODE_LSB +: MODE_W];
        flag_d[FLAG_CFG] = 1'b1;
      end
      if (addr == OFS_CMD) begin
        en_d = wdata[CMD_EN_BIT];
      end
      for (int i = 0; i < NUM_MND; i++) begin
        if (addr == MND_OFS[i]) begin
          mnd_d[i]              = wdata[MND_W-1:0];
          flag_d[MND_FLAG[i]]   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      src_q  <= '0;
      mode_q <= '0;
      mnd_q  <= '0;
      flag_q <= '0;
      en_q   <= 1'b0;
    end else begin
      div_q  <= div_d;
      src_q  <= src_d;
      mode_q <= mode_d;
      mnd_q  <= mnd_d;
      flag_q <= flag_d;
      en_q   <= en_d;
    end
  end

  assign st_div  = div_q;
  assign st_src  = src_q;
  assign st_mode = mode_q;
  assign st_mnd  = mnd_q;
  assign flags   = flag_q;
  assign en_req  = en_q;

  // R7: a change flag only rises after a write strobe
  a_r7_flag_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q != '0) && $past(flag_q) == '0 |-> $past(wr_en));
endmodule

// File: rtl/clkroot_commit.sv
module clkroot_commit #(
  parameter int SYNC_STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_req,
  output logic pending,
  output logic apply
);
  localparam int CNT_W = $clog2(SYNC_STAGES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_STAGES - 1);

  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fire;

  assign fire = pend_q && (cnt_q == CNT_LAST);

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (fire) begin
      pend_d = 1'b0;
      cnt_d  = '0;
    end else if (pend_q) begin
      cnt_d  = cnt_q + 1'b1;
    end else if (upd_req) begin
      pend_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign pending = pend_q;
  assign apply   = fire;

  // R8: the request clears on the edge after the commit cycle
  a_r8_clear_after_apply: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> !pending);

  generate
    if (SYNC_STAGES > 1) begin : g_window
      // R8: a fresh request remains visible for more than one cycle
      a_r8_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |=> pending);
    end
  endgenerate
endmodule

// File: rtl/clkroot_active.sv
module clkroot_active
  import clkroot_pkg::*;
#(
  parameter int DIV_W = 5,
  parameter int MND_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            apply,
  input  logic [NUM_FLAG-1:0]             flags,
  input  logic [DIV_W-1:0]                st_div,
  input  logic [SRC_W-1:0]                st_src,
  input  logic [MODE_W-1:0]               st_mode,
  input  logic [NUM_MND-1:0][MND_W-1:0]   st_mnd,
  output logic [DIV_W-1:0]                act_div,
  output logic [SRC_W-1:0]                act_src,
  output logic [MODE_W-1:0]               act_mode,
  output logic [NUM_MND-1:0][MND_W-1:0]   act_mnd
);
  logic                 cfg_ld;
  logic [DIV_W-1:0]     div_q;
  logic [SRC_W-1:0]     src_q;
  logic [MODE_W-1:0]    mode_q;

  assign cfg_ld = apply && flags[FLAG_CFG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      src_q  <= '0;
      mode_q <= '0;
    end else if (cfg_ld) begin
      div_q  <= st_div;
      src_q  <= st_src;
      mode_q <= st_mode;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_MND; g++) begin : g_mnd
      logic             ld;
      logic [MND_W-1:0] val_q;
      assign ld = apply && flags[MND_FLAG[g]];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  val_q <= '0;
        else if (ld) val_q <= st_mnd[g];
      end
      assign act_mnd[g] = val_q;
    end
  endgenerate

  assign act_div  = div_q;
  assign act_src  = src_q;
  assign act_mode = mode_q;

  // R9: active settings hold outside the commit cycle
  a_r9_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable({act_div, act_src, act_mode, act_mnd}));
endmodule

// File: rtl/clkroot_cfg_bank.sv
module clkroot_cfg_bank
  import clkroot_pkg::*;
#(
  parameter int DIV_W       = 5,
  parameter int MND_W       = 8,
  parameter int SYNC_STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [4:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rd_data,
  input  logic              root_on_i,
  output logic              root_en_o,
  output logic              apply_o,
  output logic [DIV_W-1:0]  act_div_o,
  output logic [2:0]        act_src_o,
  output logic [1:0]        act_mode_o,
  output logic [MND_W-1:0]  act_m_o,
  output logic [MND_W-1:0]  act_n_o,
  output logic [MND_W-1:0]  act_d_o
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [DIV_W-1:0]              st_div;
  logic [SRC_W-1:0]              st_src;
  logic [MODE_W-1:0]             st_mode;
  logic [NUM_MND-1:0][MND_W-1:0] st_mnd;
  logic [NUM_MND-1:0][MND_W-1:0] act_mnd;
  logic [NUM_FLAG-1:0]           flags;
  logic                          en_req;
  logic                          pending;
  logic                          apply;
  logic                          upd_req;

  assign upd_req = wr_en && (addr == OFS_CMD) && wdata[CMD_UPD_BIT];

  clkroot_stage #(.DIV_W(DIV_W), .MND_W(MND_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .flag_clr (apply),
    .st_div   (st_div),
    .st_src   (st_src),
    .st_mode  (st_mode),
    .st_mnd   (st_mnd),
    .flags    (flags),
    .en_req   (en_req)
  );

  clkroot_commit #(.SYNC_STAGES(SYNC_STAGES)) u_commit (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .upd_req (upd_req),
    .pending (pending),
    .apply   (apply)
  );

  clkroot_active #(.DIV_W(DIV_W), .MND_W(MND_W)) u_active (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .apply    (apply),
    .flags    (flags),
    .st_div   (st_div),
    .st_src   (st_src),
    .st_mode  (st_mode),
    .st_mnd   (st_mnd),
    .act_div  (act_div_o),
    .act_src  (act_src_o),
    .act_mode (act_mode_o),
    .act_mnd  (act_mnd)
  );

  always_comb begin
    rd_data = '0;
    if (addr == OFS_CMD) begin
      rd_data[CMD_OFF_BIT]                     = ~root_on_i;
      rd_data[CMD_FLAG_LSB +: NUM_FLAG]        = flags;
      rd_data[CMD_EN_BIT]                      = en_req;
      rd_data[CMD_UPD_BIT]                     = pending;
    end
    if (addr == OFS_CFG) begin
      rd_data[DIV_W-1:0]                       = st_div;
      rd_data[CFG_SRC_LSB +: SRC_W]            = st_src;
      rd_data[CFG_MODE_LSB +: MODE_W]          = st_mode;
    end
    for (int i = 0; i < NUM_MND; i++) begin
      if (addr == MND_OFS[i]) rd_data[MND_W-1:0] = st_mnd[i];
    end
  end

  assign root_en_o = en_req;
  assign apply_o   = apply;
  assign act_m_o   = act_mnd[0];
  assign act_n_o   = act_mnd[1];
  assign act_d_o   = act_mnd[2];

  // R9: all change flags are gone after a commit with no write alongside
  a_r9_flags_cleared: assert property (@(posedge clk) disable iff (!rst_sync_n)
    apply && !wr_en |=> flags == '0);

  // R4: counter registers never show bits above their field
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr == MND_OFS[0] || addr == MND_OFS[1] || addr == MND_OFS[2])
      |-> rd_data[31:MND_W] == '0);

  // R8: commit only ever follows a visible request
  a_r8_apply_from_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
    apply |-> pending);
endmodule

// File: tb/sim_clkroot_cfg_bank.sv
module sim_clkroot_cfg_bank;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rd_data;
  logic        root_on_i;
  logic        root_en_o;
  logic        apply_o;
  logic [4:0]  act_div_o;
  logic [2:0]  act_src_o;
  logic [1:0]  act_mode_o;
  logic [7:0]  act_m_o;
  logic [7:0]  act_n_o;
  logic [7:0]  act_d_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  clkroot_cfg_bank #(.DIV_W(5), .MND_W(8), .SYNC_STAGES(3)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .root_on_i(root_on_i), .root_en_o(root_en_o),
    .apply_o(apply_o), .act_div_o(act_div_o), .act_src_o(act_src_o),
    .act_mode_o(act_mode_o), .act_m_o(act_m_o), .act_n_o(act_n_o),
    .act_d_o(act_d_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [4:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{1'b0, 5'h00, 32'h0,         32'h0000_0000}, // R5 R1 running root, idle command
    '{1'b1, 5'h08, 32'h1234_5603, 32'h0},         // stage M
    '{1'b0, 5'h08, 32'h0,         32'h0000_0003}, // R4 only low bits kept
    '{1'b0, 5'h00, 32'h0,         32'h0000_0040}, // R7 M flag = bit 6
    '{1'b1, 5'h0C, 32'hFFFF_FFF9, 32'h0},         // stage N
    '{1'b1, 5'h04, 32'hFFFF_FFFF, 32'h0},         // stage configuration
    '{1'b0, 5'h04, 32'h0,         32'h0000_371F}, // R3 field layout
    '{1'b0, 5'h0C, 32'h0,         32'h0000_00F9}, // R4
    '{1'b0, 5'h00, 32'h0,         32'h0000_0070}, // R7 cfg bit 4, N bit 5, M bit 6
    '{1'b1, 5'h00, 32'hFFFF_FFFF, 32'h0},         // request update + enable
    '{1'b0, 5'h00, 32'h0,         32'h0000_0073}, // R8 window cycle 1
    '{1'b0, 5'h00, 32'h0,         32'h0000_0073}, // R8 window cycle 2
    '{1'b0, 5'h00, 32'h0,         32'h0000_0073}, // R8 window cycle 3
    '{1'b0, 5'h00, 32'h0,         32'h0000_0002}, // R9 flags and request cleared
    '{1'b0, 5'h10, 32'h0,         32'h0000_0000}  // R2 D unwritten
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = w;
    addr  = a;
    wdata = d;
    #1;
  endtask

  task automatic idle(input logic [4:0] a);
    cyc(1'b0, a, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = 5'h0; wdata = 32'h0; root_on_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    idle(5'h00);
    check("R1 cmd", rd_data, 32'h0);
    check("R1 outs", {23'h0, root_en_o, act_div_o, act_src_o, act_mode_o, act_m_o, act_n_o, act_d_o} & 32'hFFFF_FFFF,
          32'h0);
    idle(5'h04);
    check("R1 cfg", rd_data, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      cyc(VT[i].wr, VT[i].a, VT[i].d);
      if (!VT[i].wr) check($sformatf("vector %0d", i), rd_data, VT[i].exp);
    end

    // R9 committed values
    check("R9 act_div", {27'h0, act_div_o}, 32'h1F);
    check("R9 act_src", {29'h0, act_src_o}, 32'h7);
    check("R9 act_mode", {30'h0, act_mode_o}, 32'h3);
    check("R9 act_m", {24'h0, act_m_o}, 32'h03);
    check("R9 act_n", {24'h0, act_n_o}, 32'hF9);
    check("R9 act_d", {24'h0, act_d_o}, 32'h00);
    check("R6 root_en", {31'h0, root_en_o}, 32'h1);

    // R9 active value held until the commit edge
    cyc(1'b1, 5'h10, 32'h0000_ABCD);
    cyc(1'b1, 5'h00, 32'h0000_0003);
    for (int k = 0; k < 3; k++) begin
      idle(5'h00);
      check("R9 d held", {24'h0, act_d_o}, 32'h00);
    end
    idle(5'h00);
    check("R9 d applied", {24'h0, act_d_o}, 32'hCD);
    check("R9 cmd after", rd_data, 32'h2);

    // R8 writes to bit 0 inside the window neither cancel nor restart
    cyc(1'b1, 5'h00, 32'h3);
    cyc(1'b1, 5'h00, 32'h2);
    cyc(1'b1, 5'h00, 32'h3);
    check("R8 not cancelled", rd_data, 32'h3);
    idle(5'h00);
    check("R8 still pending", rd_data, 32'h3);
    idle(5'h00);
    check("R8 not restarted", rd_data, 32'h2);

    // R10 staging write on the commit edge
    cyc(1'b1, 5'h00, 32'h3);
    idle(5'h00);
    idle(5'h00);
    cyc(1'b1, 5'h08, 32'h0000_0055);
    idle(5'h00);
    check("R10 act_m old", {24'h0, act_m_o}, 32'h03);
    check("R10 flag kept", rd_data, 32'h42);
    idle(5'h08);
    check("R10 staged m", rd_data, 32'h55);
    cyc(1'b1, 5'h00, 32'h3);
    repeat (3) idle(5'h00);
    idle(5'h00);
    check("R10 second commit", {24'h0, act_m_o}, 32'h55);

    // R2 unmapped addresses
    idle(5'h14);
    check("R2 read 0x14", rd_data, 32'h0);
    idle(5'h02);
    check("R2 read 0x02", rd_data, 32'h0);
    cyc(1'b1, 5'h14, 32'hFFFF_FFFF);
    cyc(1'b1, 5'h1C, 32'hFFFF_FFFF);
    idle(5'h00);
    check("R2 no flag", rd_data, 32'h2);

    // R3 unused configuration bits dropped
    cyc(1'b1, 5'h04, 32'hFFFF_D6E9);
    idle(5'h04);
    check("R3 cfg mask", rd_data, 32'h0000_1609);

    // R6 enable acts at once, R5 stopped-root status
    cyc(1'b1, 5'h00, 32'h8000_0000);
    idle(5'h00);
    check("R6 root_en off", {31'h0, root_en_o}, 32'h0);
    check("R5 bit31 ignored", rd_data, 32'h10);
    root_on_i = 1'b0;
    #1;
    check("R5 root stopped", rd_data, 32'h8000_0010);
    root_on_i = 1'b1;
    cyc(1'b1, 5'h00, 32'h2);
    idle(5'h00);
    check("R6 root_en on", {31'h0, root_en_o}, 32'h1);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule